// File: doc/BRIEF.md
# Region Write-Protection Gate

This block sits in front of a memory's write path and decides, for each write request, whether the write may proceed. The address space it guards has six regions: four flash sectors, an EEPROM area and a boot area. Each region has a non-volatile protect bit. A bit holds 1 when it is erased, which leaves the region open. Programming the bit to 0 closes the region for good. The EEPROM and the four sectors also have a volatile override. The override reopens a closed region until the next reset, or until it is withdrawn. The boot area has no override.

Both kinds of state change only through a set-protection strobe that carries one data byte. A data bit of 1 at a region's position raises that region's override. A data bit of 0 programs the non-volatile bit, if it is still erased, and withdraws any override. A lock block outside this design supplies two status bits and a test-mode flag. When the test-mode bypass condition holds, every write is granted. The result appears one clock after the request as either a grant pulse or a deny pulse. An 8-bit status byte shows the effective open or closed state of every region together with the two lock bits.

Top module: `regionWriteGate`

## Requirements
- R1: After power-on reset (`porN` low) and reset (`rstN` low), `writeGrant` and `writeDeny` are 0 and `protReg` equals `{lockStatus, 6'b111111}`.
- R2: A request sampled on a rising edge produces exactly one of `writeGrant` or `writeDeny`, high for one cycle after that edge. A cycle without a request produces neither.
- R3: A request whose address lies in none of the six regions is always granted.
- R4: A set-protection byte with 0 at bit 5 (boot), bit 4 (EEPROM) or bit k (sector k, k = 0..3) permanently programs that region's non-volatile bit to 0. Requests to that region are then denied. The programmed state survives `rstN` and is cleared only by `porN`.
- R5: A set-protection byte with 1 at bit 4 or at bit k (k = 0..3) raises that region's override, and requests to it are granted even though its non-volatile bit is 0.
- R6: `rstN` drops every override, and regions with a programmed non-volatile bit become closed again.
- R7: A set-protection byte with 0 at an overridden region's bit withdraws that override, and the region is closed again.
- R8: Once the boot bit (bit 5) is programmed, no set-protection byte reopens the boot area, and `protReg[5]` stays 0.
- R9: When `testMode` is 1 and either `lockStatus[1]` (test-mode-disable) is 1 or `lockStatus[0]` (password-OK, active low) is 0, every request is granted.
- R10: `protReg[7:6]` equals `lockStatus`. Each of `protReg[5:0]` is 1 when the matching region is effectively open. Bits 7:6 of the set-protection byte have no effect.
- R11: A set-protection operation takes effect for requests sampled on later edges. A request sampled on the same edge as the operation is judged against the earlier state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the overrides and outputs |
| porN | input | 1 | Asynchronous active-low power-on reset; returns the non-volatile bits to erased |
| wrReq | input | 1 | Write request, valid for one cycle |
| wrAddr | input | ADDR_W | Address of the write request |
| setProt | input | 1 | Set-protection strobe |
| setData | input | 8 | Set-protection data byte |
| testMode | input | 1 | Test mode active, from the lock block |
| lockStatus | input | 2 | Bit 1 test-mode-disable, bit 0 password-OK (0 = correct), from the lock block |
| writeGrant | output | 1 | Registered grant, one cycle after the request |
| writeDeny | output | 1 | Registered deny, one cycle after the request |
| protReg | output | 8 | Status byte: lock bits and effective region state (1 = open) |

## Verification
`writeGrant` and `writeDeny` are due on the first rising edge after the edge that samples `wrReq`. The protection state, and with it `protReg`, changes on the edge that samples `setProt`. The bench drives every input on a falling edge and reads the results at the next falling edge, so each registered result is read half a cycle after it settles. To check R11, the bench drives a request and a set-protection operation in the same cycle. It expects that request to be judged on the old state and the following request on the new one.

// File: rtl/wgPkg.sv
`timescale 1ns/1ps
package wgPkg;
  localparam int SECT_CNT   = 4;
  localparam int OVR_CNT    = SECT_CNT + 1;   // sectors + EEPROM
  localparam int REGION_CNT = SECT_CNT + 2;   // + boot
  localparam int EE_IDX     = SECT_CNT;
  localparam int BOOT_IDX   = SECT_CNT + 1;

  typedef struct packed {
    logic [REGION_CNT-1:0] nvClr;   // program non-volatile bit to 0
    logic [OVR_CNT-1:0]    ovrSet;  // raise volatile override
    logic [OVR_CNT-1:0]    ovrClr;  // withdraw volatile override
    logic                  bypass;  // test-mode bypass of all protection
  } wgStrobes_t;
endpackage

// File: rtl/wgControl.sv
`timescale 1ns/1ps
module wgControl
  import wgPkg::*;
(
  input  logic       setProt,
  input  logic [7:0] setData,
  input  logic       testMode,
  input  logic [1:0] lockStatus,
  output wgStrobes_t stb
);
  logic unusedDataHi;
  assign unusedDataHi = ^setData[7:6];

  always_comb begin
    stb.nvClr  = {REGION_CNT{setProt}} & ~setData[REGION_CNT-1:0];
    stb.ovrSet = {OVR_CNT{setProt}}    &  setData[OVR_CNT-1:0];
    stb.ovrClr = {OVR_CNT{setProt}}    & ~setData[OVR_CNT-1:0];
    stb.bypass = testMode & (lockStatus[1] | ~lockStatus[0]);
  end
endmodule

// File: rtl/wgDatapath.sv
`timescale 1ns/1ps
module wgDatapath
  import wgPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [REGION_CNT*ADDR_W-1:0] REGION_LO = '0,
  parameter logic [REGION_CNT*ADDR_W-1:0] REGION_HI = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  porN,
  input  wgStrobes_t            stb,
  input  logic                  wrReq,
  input  logic [ADDR_W-1:0]     wrAddr,
  output logic                  writeGrant,
  output logic                  writeDeny,
  output logic [REGION_CNT-1:0] effOpen
);
  logic [REGION_CNT-1:0] nvBits;
  logic [OVR_CNT-1:0]    ovrBits;
  logic [REGION_CNT-1:0] hit;
  logic [REGION_CNT-1:0] closed;
  logic                  blocked;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) nvBits <= '1;
    else       nvBits <= nvBits & ~stb.nvClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovrBits <= '0;
    else       ovrBits <= (ovrBits | stb.ovrSet) & ~stb.ovrClr;
  end

  for (genvar i = 0; i < REGION_CNT; i++) begin : g_region
    localparam logic [ADDR_W-1:0] LO = REGION_LO[i*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] HI = REGION_HI[i*ADDR_W +: ADDR_W];
    assign hit[i] = (wrAddr >= LO) && (wrAddr <= HI);
    if (i == BOOT_IDX) begin : g_boot
      assign closed[i] = ~nvBits[i];
    end else begin : g_ovr
      assign closed[i] = ~nvBits[i] & ~ovrBits[i];
    end
  end

  assign effOpen = ~closed;
  assign blocked = (|(hit & closed)) & ~stb.bypass;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeGrant <= 1'b0;
      writeDeny  <= 1'b0;
    end else begin
      writeGrant <= wrReq & ~blocked;
      writeDeny  <= wrReq &  blocked;
    end
  end
endmodule

// File: rtl/regionWriteGate.sv
`timescale 1ns/1ps
module regionWriteGate
  import wgPkg::*;
#(
  parameter int ADDR_W = 24,
  // per region, lowest index first: sector0..3, EEPROM, boot
  parameter logic [REGION_CNT*ADDR_W-1:0] REGION_LO =
    {24'h230000, 24'h220000, 24'h030000, 24'h020000, 24'h010000, 24'h000000},
  parameter logic [REGION_CNT*ADDR_W-1:0] REGION_HI =
    {24'h231FFF, 24'h2203FF, 24'h03FFFF, 24'h02FFFF, 24'h01FFFF, 24'h00FFFF}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              setProt,
  input  logic [7:0]        setData,
  input  logic              testMode,
  input  logic [1:0]        lockStatus,
  output logic              writeGrant,
  output logic              writeDeny,
  output logic [7:0]        protReg
);
  wgStrobes_t            stb;
  logic [REGION_CNT-1:0] effOpen;

  wgControl u_ctrl (
    .setProt(setProt), .setData(setData), .testMode(testMode),
    .lockStatus(lockStatus), .stb(stb)
  );

  wgDatapath #(.ADDR_W(ADDR_W), .REGION_LO(REGION_LO), .REGION_HI(REGION_HI)) u_dp (
    .clk(clk), .rstN(rstN), .porN(porN), .stb(stb), .wrReq(wrReq),
    .wrAddr(wrAddr), .writeGrant(writeGrant), .writeDeny(writeDeny),
    .effOpen(effOpen)
  );

  assign protReg = {lockStatus, effOpen};
endmodule

// File: rtl/wgChecker.sv
`timescale 1ns/1ps
module wgChecker
  import wgPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [REGION_CNT*ADDR_W-1:0] REGION_LO = '0,
  parameter logic [REGION_CNT*ADDR_W-1:0] REGION_HI = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic              porN,
  input logic              wrReq,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              testMode,
  input logic [1:0]        lockStatus,
  input logic              writeGrant,
  input logic              writeDeny,
  input logic [7:0]        protReg
);
  logic anyHit;
  always_comb begin
    anyHit = 1'b0;
    for (int i = 0; i < REGION_CNT; i++)
      if (wrAddr >= REGION_LO[i*ADDR_W +: ADDR_W] && wrAddr <= REGION_HI[i*ADDR_W +: ADDR_W])
        anyHit = 1'b1;
  end

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(writeGrant && writeDeny));
  a_r2_idle: assert property (@(posedge clk) disable iff (!rstN)
    !wrReq |=> (!writeGrant && !writeDeny));
  a_r2_answer: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> (writeGrant || writeDeny));
  a_r3_outside: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !anyHit) |=> writeGrant);
  a_r9_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && testMode && (lockStatus[1] || !lockStatus[0])) |=> writeGrant);
  a_r8_boot_sticky: assert property (@(posedge clk) disable iff (!porN)
    !protReg[5] |=> !protReg[5]);
  a_r10_lock_bits: assert property (@(posedge clk) disable iff (!rstN)
    protReg[7:6] == lockStatus);
endmodule

bind regionWriteGate wgChecker #(.ADDR_W(ADDR_W), .REGION_LO(REGION_LO), .REGION_HI(REGION_HI)) u_chk (
  .clk(clk), .rstN(rstN), .porN(porN), .wrReq(wrReq), .wrAddr(wrAddr),
  .testMode(testMode), .lockStatus(lockStatus), .writeGrant(writeGrant),
  .writeDeny(writeDeny), .protReg(protReg)
);

// File: tb/test_regionWriteGate.sv
`timescale 1ns/1ps
module test_regionWriteGate;
  localparam logic [23:0] A_S0 = 24'h000100, A_S1 = 24'h018000, A_EE = 24'h220010,
                          A_BOOT = 24'h231000, A_OUT = 24'h100000;
  logic clk = 1'b0, rstN = 1'b0, porN = 1'b0;
  logic wrReq = 1'b0, setProt = 1'b0, testMode = 1'b0;
  logic [23:0] wrAddr = '0;
  logic [7:0]  setData = '0;
  logic [1:0]  lockStatus = 2'b01;
  logic writeGrant, writeDeny;
  logic [7:0] protReg;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  regionWriteGate i_regionWriteGate (
    .clk(clk), .rstN(rstN), .porN(porN), .wrReq(wrReq), .wrAddr(wrAddr),
    .setProt(setProt), .setData(setData), .testMode(testMode),
    .lockStatus(lockStatus), .writeGrant(writeGrant), .writeDeny(writeDeny),
    .protReg(protReg)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // request at a falling edge, read result at the next falling edge
  task automatic request(string req, logic [23:0] a, logic expGrant);
    @(negedge clk); wrReq = 1'b1; wrAddr = a;
    @(negedge clk); wrReq = 1'b0;
    chk(req, {6'b0, writeGrant, writeDeny}, {6'b0, expGrant, ~expGrant});
  endtask

  task automatic setProtOp(logic [7:0] d);
    @(negedge clk); setProt = 1'b1; setData = d;
    @(negedge clk); setProt = 1'b0;
  endtask

  task automatic pulseRst();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic tReset();
    repeat (2) @(negedge clk);
    chk("R1 grant/deny", {6'b0, writeGrant, writeDeny}, 8'h00);
    porN = 1'b1; rstN = 1'b1;
    @(negedge clk);
    chk("R1 protReg", protReg, 8'h7F);
  endtask

  task automatic tErased();
    request("R2 sector1 erased", A_S1, 1'b1);
    request("R2 boot erased", A_BOOT, 1'b1);
    request("R3 outside", A_OUT, 1'b1);
    @(negedge clk);
    chk("R2 idle", {6'b0, writeGrant, writeDeny}, 8'h00);
  endtask

  task automatic tProgram();
    setProtOp(8'h0D);                       // program boot, EEPROM, sector1
    chk("R10 protReg after program", protReg, 8'h4D);
    request("R4 EEPROM closed", A_EE, 1'b0);
    request("R4 sector1 closed", A_S1, 1'b0);
    request("R4 sector0 open", A_S0, 1'b1);
    request("R4 boot closed", A_BOOT, 1'b0);
    request("R3 outside with closures", A_OUT, 1'b1);
    pulseRst();
    chk("R4 survives rstN", protReg, 8'h4D);
    request("R4 sector1 closed after rstN", A_S1, 1'b0);
  endtask

  task automatic tLift();
    setProtOp(8'hFF);
    chk("R5 protReg after lift", protReg, 8'h5F);
    request("R5 EEPROM lifted", A_EE, 1'b1);
    request("R5 sector1 lifted", A_S1, 1'b1);
    request("R8 boot not lifted", A_BOOT, 1'b0);
    chk("R8 protReg bit5", {7'b0, protReg[5]}, 8'h00);
  endtask

  task automatic tSameCycle();
    @(negedge clk); setProt = 1'b1; setData = 8'hFD; wrReq = 1'b1; wrAddr = A_S1;
    @(negedge clk); setProt = 1'b0; wrReq = 1'b0;
    chk("R11 same-cycle uses old state", {6'b0, writeGrant, writeDeny}, 8'h02);
    chk("R7 protReg after withdraw", protReg, 8'h5D);
    request("R7 sector1 closed again", A_S1, 1'b0);
    request("R7 EEPROM still lifted", A_EE, 1'b1);
  endtask

  task automatic tResetLift();
    pulseRst();
    chk("R6 protReg after rstN", protReg, 8'h4D);
    request("R6 EEPROM closed after rstN", A_EE, 1'b0);
  endtask

  task automatic tBypass();
    testMode = 1'b1; lockStatus = 2'b11;
    @(negedge clk);
    chk("R10 lock bits", protReg, 8'hCD);
    request("R9 bypass by disable bit", A_BOOT, 1'b1);
    lockStatus = 2'b00;
    request("R9 bypass by password", A_EE, 1'b1);
    chk("R10 lock bits 00", protReg, 8'h0D);
    lockStatus = 2'b01;
    request("R9 no bypass when locked", A_BOOT, 1'b0);
    testMode = 1'b0; lockStatus = 2'b11;
    request("R9 no bypass outside test mode", A_EE, 1'b0);
    lockStatus = 2'b01;
  endtask

  task automatic tPor();
    @(negedge clk); porN = 1'b0;
    @(negedge clk); porN = 1'b1;
    chk("R1 protReg after porN", protReg, 8'h7F);
    request("R1 boot open after porN", A_BOOT, 1'b1);
  endtask

  initial begin
    #50000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tReset();
    tErased();
    tProgram();
    tLift();
    tSameCycle();
    tResetLift();
    tBypass();
    tPor();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule